// File: doc/BRIEF.md
# Serial Response Frame Checker

This block sits on the receive side of a serial debug link. After a command goes out, the target sends back a short response frame. The block collects that frame one bit at a time and decides whether the exchange succeeded. The frame starts with a start bit of 1 and then carries a 4-bit tag whose two low bits form an acknowledge code. A 32-bit data word follows only for an accepted read. A 4-bit check nibble closes the frame.

A running CRC is kept over the whole frame, including the received check nibble, and the frame is valid only if that CRC ends at zero. The block then reports one of three outcomes: success, CRC error or target-acknowledge error. It publishes the tag, the check nibble and any read data, and it raises one of two one-cycle strobes. The command encoder uses these strobes to either refresh or drop its remembered last address.

Top module: `resp_frame_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `o_status` is IDLE (0), `o_done`, `o_addr_update` and `o_addr_invalidate` are 0, and `o_tag`, `o_ack_code`, `o_rx_crc` and `o_rd_data` are 0.
- R2: A frame is a start bit (accepted when `i_bit_valid` and `i_start` are both high), then 4 tag bits sent MSB first. The acknowledge code is tag bit 1 and tag bit 0, and 0 means accepted. `i_cmd_read` is sampled with the start bit. A 32-bit data word (MSB first) follows the tag only when the code is 0 and the command was a read. Otherwise the 4-bit check nibble (MSB first) follows the tag directly.
- R3: The CRC uses x^4+x^2+x+1 with an initial value of 0 and is updated once per accepted bit. It covers the start bit, the tag, any data and the received check nibble. The frame passes only when the final value is 0. `o_rx_crc` shows the received nibble.
- R4: A frame that fails the CRC reports CRC_ERR (3) and pulses `o_addr_invalidate`, whatever its acknowledge code.
- R5: A frame that passes the CRC but has a non-zero acknowledge code reports ACK_ERR (4), shows the code on `o_ack_code` and pulses `o_addr_invalidate`.
- R6: A frame that passes the CRC with code 0 reports OK (2) and pulses `o_addr_update`. `o_rd_data` shows the received word when a payload was present and 0 when it was not, for every outcome.
- R7: `o_done` is high for exactly one cycle, the cycle after the last check bit is accepted. Exactly one strobe is high in that cycle and no strobe is high at any other time.
- R8: Bits are taken only in cycles where `i_bit_valid` is high. `i_bit` and `i_start` have no effect in any other cycle, and any idle gaps between bits do not change the result.
- R9: `o_status` is BUSY (1) from the cycle after a start bit until `o_done`. `o_tag`, `o_rx_crc` and `o_rd_data` change only together with `o_done`. A start bit in the middle of a frame drops that frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_bit_valid | input | 1 | Qualifies `i_bit` for this cycle |
| i_bit | input | 1 | Serial response bit |
| i_start | input | 1 | Marks this bit as a frame start bit |
| i_cmd_read | input | 1 | The outstanding command was a read (sampled with the start bit) |
| o_done | output | 1 | One-cycle frame-complete pulse |
| o_status | output | 3 | 0 IDLE, 1 BUSY, 2 OK, 3 CRC_ERR, 4 ACK_ERR |
| o_ack_code | output | 2 | Acknowledge code of the last frame |
| o_tag | output | 4 | Tag of the last frame |
| o_rx_crc | output | 4 | Received check nibble of the last frame |
| o_rd_data | output | 32 | Read data of the last frame, or 0 |
| o_addr_update | output | 1 | Strobe: remembered address is still valid |
| o_addr_invalidate | output | 1 | Strobe: drop the remembered address |

## Verification
A wrong internal state shows up at the ports exactly one cycle after the last check bit. A wrong phase length moves the `o_done` pulse by one or more bit slots, or lets the block wait for a payload that never arrives. A wrong CRC register flips the result between OK and CRC_ERR and swaps the strobes. A bad shift register gives the wrong tag, data or nibble in the same done cycle. Because the bench predicts every output on every clock, any of these faults is reported in the first cycle it appears.

// File: rtl/resp_chk_pkg.sv
package resp_chk_pkg;

    localparam int TAG_W  = 4;
    localparam int ACK_W  = 2;
    localparam int DATA_W = 32;
    localparam int CRC_W  = 4;
    localparam int CNT_W  = $clog2(DATA_W);

    // x^4 + x^2 + x + 1 without the x^4 term
    localparam logic [CRC_W-1:0] CRC_POLY = 4'b0111;

    typedef enum logic [2:0] {
        RS_IDLE    = 3'd0,
        RS_BUSY    = 3'd1,
        RS_OK      = 3'd2,
        RS_CRC_ERR = 3'd3,
        RS_ACK_ERR = 3'd4
    } resp_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_TAG,
        PH_DATA,
        PH_CRC
    } phase_e;

    typedef struct packed {
        logic take_tag;
        logic take_data;
        logic take_crc;
    } take_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic [CRC_W-2:0]  crc_hi;
    } capture_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/resp_crc_serial.sv
module resp_crc_serial
    import resp_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             i_clear,
    input  logic             i_shift,
    input  logic             i_bit,
    output logic [CRC_W-1:0] o_crc_next
);

    logic [CRC_W-1:0] crc_q;

    always_comb begin
        if (i_clear)
            o_crc_next = crc_step('0, i_bit);
        else
            o_crc_next = crc_step(crc_q, i_bit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= '0;
        else if (i_clear || i_shift)
            crc_q <= o_crc_next;
    end

    // R3: a start bit of 1 seeds the register from zero
    p_crc_seed_r3: assert property (@(posedge clk) disable iff (rst)
        (i_clear && i_bit) |=> (crc_q == CRC_POLY));

endmodule

// File: rtl/resp_capture.sv
module resp_capture
    import resp_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     i_clear,
    input  take_t    i_take,
    input  logic     i_bit,
    output capture_t o_cap
);

    capture_t cap_q;

    always_ff @(posedge clk) begin
        if (rst || i_clear) begin
            cap_q <= '0;
        end else begin
            if (i_take.take_tag)
                cap_q.tag <= {cap_q.tag[TAG_W-2:0], i_bit};
            if (i_take.take_data)
                cap_q.data <= {cap_q.data[DATA_W-2:0], i_bit};
            if (i_take.take_crc)
                cap_q.crc_hi <= {cap_q.crc_hi[CRC_W-3:0], i_bit};
        end
    end

    assign o_cap = cap_q;

    // R8: fields only shift when a bit is taken
    p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!i_clear && !i_take.take_data) |=> $stable(cap_q.data));

endmodule

// File: rtl/resp_frame_seq.sv
module resp_frame_seq
    import resp_chk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  i_valid,
    input  logic  i_start,
    input  logic  i_bit,
    input  logic  i_is_read,
    input  logic  i_tag_low,
    output logic  o_frame_start,
    output take_t o_take,
    output logic  o_last
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rd_q;
    logic [ACK_W-1:0] ack_now;
    logic             has_payload;

    assign o_frame_start = i_valid && i_start;
    assign ack_now       = {i_tag_low, i_bit};
    assign has_payload   = (ack_now == '0) && rd_q;

    always_comb begin
        o_take = '0;
        if (i_valid && !i_start) begin
            o_take.take_tag  = (phase_q == PH_TAG);
            o_take.take_data = (phase_q == PH_DATA);
            o_take.take_crc  = (phase_q == PH_CRC);
        end
    end

    assign o_last = o_take.take_crc && (cnt_q == CNT_W'(CRC_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
        end else if (o_frame_start) begin
            phase_q <= PH_TAG;
            cnt_q   <= '0;
            rd_q    <= i_is_read;
        end else if (i_valid) begin
            unique case (phase_q)
                PH_TAG: begin
                    if (cnt_q == CNT_W'(TAG_W - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= has_payload ? PH_DATA : PH_CRC;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == CNT_W'(DATA_W - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_CRC;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CRC: begin
                    if (cnt_q == CNT_W'(CRC_W - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // R8: an idle sequencer leaves idle only through a start bit
    p_idle_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !o_frame_start) |=> (phase_q == PH_IDLE));

    // R2: a payload is only entered for a read whose code is 0
    p_payload_rule_r2: assert property (@(posedge clk) disable iff (rst)
        (o_take.take_tag && cnt_q == CNT_W'(TAG_W - 1) && !has_payload) |=> (phase_q == PH_CRC));

endmodule

// File: rtl/resp_frame_checker.sv
module resp_frame_checker
    import resp_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_bit_valid,
    input  logic              i_bit,
    input  logic              i_start,
    input  logic              i_cmd_read,
    output logic              o_done,
    output logic [2:0]        o_status,
    output logic [ACK_W-1:0]  o_ack_code,
    output logic [TAG_W-1:0]  o_tag,
    output logic [CRC_W-1:0]  o_rx_crc,
    output logic [DATA_W-1:0] o_rd_data,
    output logic              o_addr_update,
    output logic              o_addr_invalidate
);

    logic             frame_start;
    take_t            take;
    logic             last_bit;
    capture_t         cap;
    logic [CRC_W-1:0] crc_next;
    resp_status_e     status_q;

    resp_frame_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .i_valid      (i_bit_valid),
        .i_start      (i_start),
        .i_bit        (i_bit),
        .i_is_read    (i_cmd_read),
        .i_tag_low    (cap.tag[0]),
        .o_frame_start(frame_start),
        .o_take       (take),
        .o_last       (last_bit)
    );

    resp_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .i_clear(frame_start),
        .i_take (take),
        .i_bit  (i_bit),
        .o_cap  (cap)
    );

    resp_crc_serial u_crc (
        .clk       (clk),
        .rst       (rst),
        .i_clear   (frame_start),
        .i_shift   (take.take_tag || take.take_data || take.take_crc),
        .i_bit     (i_bit),
        .o_crc_next(crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q          <= RS_IDLE;
            o_done            <= 1'b0;
            o_addr_update     <= 1'b0;
            o_addr_invalidate <= 1'b0;
            o_tag             <= '0;
            o_rx_crc          <= '0;
            o_rd_data         <= '0;
        end else begin
            o_done            <= 1'b0;
            o_addr_update     <= 1'b0;
            o_addr_invalidate <= 1'b0;
            if (frame_start) begin
                status_q <= RS_BUSY;
            end else if (last_bit) begin
                o_done    <= 1'b1;
                o_tag     <= cap.tag;
                o_rd_data <= cap.data;
                o_rx_crc  <= {cap.crc_hi, i_bit};
                if (crc_next != '0) begin
                    status_q          <= RS_CRC_ERR;
                    o_addr_invalidate <= 1'b1;
                end else if (cap.tag[ACK_W-1:0] != '0) begin
                    status_q          <= RS_ACK_ERR;
                    o_addr_invalidate <= 1'b1;
                end else begin
                    status_q      <= RS_OK;
                    o_addr_update <= 1'b1;
                end
            end
        end
    end

    assign o_status   = status_q;
    assign o_ack_code = o_tag[ACK_W-1:0];

    // R7: the two strobes never coincide
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(o_addr_update && o_addr_invalidate));

    // R7: strobes only appear with done, and done carries one of them
    p_strobe_done_r7: assert property (@(posedge clk) disable iff (rst)
        o_done == (o_addr_update || o_addr_invalidate));

    // R7: done never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        o_done |=> !o_done);

    // R6: success always refreshes the remembered address
    p_ok_update_r6: assert property (@(posedge clk) disable iff (rst)
        (o_done && status_q == RS_OK) |-> o_addr_update);

    // R5: a target error always carries a non-zero code
    p_ack_code_r5: assert property (@(posedge clk) disable iff (rst)
        (o_done && status_q == RS_ACK_ERR) |-> (o_ack_code != '0));

    // R9: published fields move only with done
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !o_done |-> ($stable(o_rd_data) && $stable(o_tag) && $stable(o_rx_crc)));

    // R9: a busy checker has not finished
    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (status_q == RS_BUSY) |-> !o_done);

endmodule

// File: tb/test_resp_frame_checker.sv
module test_resp_frame_checker;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        start = 1'b0;
    logic        cmd_read = 1'b0;
    logic        done;
    logic [2:0]  status;
    logic [1:0]  ack_code;
    logic [3:0]  tag;
    logic [3:0]  rx_crc;
    logic [31:0] rd_data;
    logic        addr_update;
    logic        addr_invalidate;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic        m_done, m_upd, m_inv, m_rd, m_active;
    logic [2:0]  m_status;
    logic [3:0]  m_tag, m_crc;
    logic [31:0] m_data;
    logic        m_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    resp_frame_checker i_resp_frame_checker (
        .clk(clk), .rst(rst), .i_bit_valid(bit_valid), .i_bit(bit_in),
        .i_start(start), .i_cmd_read(cmd_read), .o_done(done), .o_status(status),
        .o_ack_code(ack_code), .o_tag(tag), .o_rx_crc(rx_crc), .o_rd_data(rd_data),
        .o_addr_update(addr_update), .o_addr_invalidate(addr_invalidate)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // remainder of a bit string (MSB first) modulo x^4+x^2+x+1
    function automatic logic [3:0] poly_rem(input logic q[$]);
        logic [4:0] r = '0;
        foreach (q[i]) begin
            r = {r[3:0], q[i]};
            if (r[4]) r = r ^ 5'b10111;
        end
        return r[3:0];
    endfunction

    function automatic void model_bit(input logic v, input logic s, input logic b, input logic rd);
        int need;
        logic [3:0] t;
        m_done = 1'b0; m_upd = 1'b0; m_inv = 1'b0;
        if (!v) return;
        if (s) begin
            m_q = {b}; m_rd = rd; m_active = 1'b1; m_status = 3'd1;
            return;
        end
        if (!m_active) return;
        m_q.push_back(b);
        if (m_q.size() < 5) return;
        t = {m_q[1], m_q[2], m_q[3], m_q[4]};
        need = (t[1:0] == 2'b00 && m_rd) ? 41 : 9;
        if (m_q.size() != need) return;
        m_active = 1'b0;
        m_done = 1'b1;
        m_tag = t;
        m_data = '0;
        if (need == 41) for (int i = 0; i < 32; i++) m_data[31-i] = m_q[5+i];
        for (int i = 0; i < 4; i++) m_crc[3-i] = m_q[need-4+i];
        if (poly_rem(m_q) != 4'd0) begin m_status = 3'd3; m_inv = 1'b1; end
        else if (t[1:0] != 2'b00)  begin m_status = 3'd4; m_inv = 1'b1; end
        else                       begin m_status = 3'd2; m_upd = 1'b1; end
    endfunction

    task automatic compare_all();
        check("R7", "done", done, m_done);
        check("R9", "status", status, m_status);
        check("R6", "update", addr_update, m_upd);
        check("R4", "invalidate", addr_invalidate, m_inv);
        check("R2", "tag", tag, m_tag);
        check("R5", "ack_code", ack_code, m_tag[1:0]);
        check("R3", "rx_crc", rx_crc, m_crc);
        check("R6", "rd_data", rd_data, m_data);
    endtask

    // compare at the falling edge, then drive the next inputs
    task automatic tick(input logic v, input logic s, input logic b, input logic rd);
        @(negedge clk);
        compare_all();
        bit_valid = v; start = s; bit_in = b; cmd_read = rd;
        model_bit(v, s, b, rd);
    endtask

    function automatic void build(input logic rd, input logic [3:0] t, input logic [31:0] d,
                                  input logic bad, ref logic q[$]);
        logic z[$];
        logic [3:0] c;
        q = {1'b1};
        for (int i = 3; i >= 0; i--) q.push_back(t[i]);
        if (rd && t[1:0] == 2'b00) for (int i = 31; i >= 0; i--) q.push_back(d[i]);
        z = q;
        for (int i = 0; i < 4; i++) z.push_back(1'b0);
        c = poly_rem(z);
        if (bad) c = c ^ 4'b0100;
        for (int i = 3; i >= 0; i--) q.push_back(c[i]);
    endfunction

    task automatic send(input logic rd, input logic [3:0] t, input logic [31:0] d,
                        input logic bad, input int gap);
        logic q[$];
        build(rd, t, d, bad, q);
        foreach (q[i]) begin
            for (int g = 0; g < gap; g++) tick(1'b0, $urandom_range(1), $urandom_range(1), ~rd);
            tick(1'b1, (i == 0), q[i], rd);
        end
        tick(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, $urandom_range(1), 1'b0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic q[$];
        m_done = 0; m_upd = 0; m_inv = 0; m_rd = 0; m_active = 0;
        m_status = 3'd0; m_tag = '0; m_crc = '0; m_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "status after reset", status, 3'd0);
        check("R1", "done after reset", done, 1'b0);
        check("R1", "rd_data after reset", rd_data, 32'd0);
        check("R1", "strobes after reset", {addr_update, addr_invalidate}, 2'b00);

        // R2 R6: accepted read carries payload
        send(1'b1, 4'b1000, 32'hDEADBEEF, 1'b0, 0);
        check("R6", "read ok status", status, 3'd2);
        check("R6", "read data", rd_data, 32'hDEADBEEF);
        // R2: accepted write has no payload
        send(1'b0, 4'b0100, 32'hFFFFFFFF, 1'b0, 0);
        check("R6", "write ok data zero", rd_data, 32'd0);
        // R5: target errors on a read skip the payload
        send(1'b1, 4'b0001, 32'h12345678, 1'b0, 0);
        check("R5", "ack err code 1", ack_code, 2'd1);
        send(1'b1, 4'b1110, 32'h0, 1'b0, 0);
        check("R5", "ack err code 2", ack_code, 2'd2);
        send(1'b0, 4'b0011, 32'h0, 1'b0, 0);
        check("R5", "ack err status", status, 3'd4);
        // R4: CRC errors, including with non-zero code
        send(1'b1, 4'b0000, 32'hA5A55A5A, 1'b1, 0);
        check("R4", "crc err read", status, 3'd3);
        send(1'b0, 4'b0010, 32'h0, 1'b1, 0);
        check("R4", "crc err beats ack err", status, 3'd3);
        // R8: gaps with toggling inputs between bits
        send(1'b1, 4'b0000, 32'h0F0F1234, 1'b0, 2);
        check("R8", "gapped read data", rd_data, 32'h0F0F1234);
        // R3: all-zero and all-one payloads
        send(1'b1, 4'b1100, 32'h00000000, 1'b0, 0);
        send(1'b1, 4'b1100, 32'hFFFFFFFF, 1'b0, 0);
        check("R3", "ones payload status", status, 3'd2);
        // R9: outputs hold while idle
        idle(20);
        check("R9", "held data", rd_data, 32'hFFFFFFFF);
        // R9: restart mid-frame
        build(1'b1, 4'b0000, 32'h11112222, 1'b0, q);
        for (int i = 0; i < 12; i++) tick(1'b1, (i == 0), q[i], 1'b1);
        check("R9", "busy mid-frame", status, 3'd1);
        send(1'b0, 4'b1000, 32'h0, 1'b0, 0);
        check("R9", "restart result", status, 3'd2);
        // R7: back-to-back frames with no idle slot
        build(1'b0, 4'b0100, 32'h0, 1'b0, q);
        foreach (q[i]) tick(1'b1, (i == 0), q[i], 1'b0);
        send(1'b1, 4'b0000, 32'hCAFEF00D, 1'b0, 0);
        check("R7", "back-to-back data", rd_data, 32'hCAFEF00D);
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule